// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a write-through first-level data cache and the next level of memory. Every store the processor makes is placed in a small queue of address/data pairs and the processor carries on without waiting; the queue is emptied toward memory one word at a time, oldest first, over a single memory port.

A read miss does not have to wait behind those stores. Its address is compared against every entry still held. When one or more entries hold that address, the read is answered from the newest of them, one cycle later, without touching memory. When none does, the read is issued on the memory port ahead of any store that has not yet started. Only one memory transaction is ever in flight, and a store already on the port is allowed to finish first.

Top module: `wbuf_bypass_top`

## Requirements
- R1: After reset, wr_ready and rd_ready are 1 while mem_req and rsp_valid are 0.
- R2: A write is taken on a clock edge where wr_valid and wr_ready are both 1; wr_ready is 0 exactly when the buffer holds 4 entries, and a write offered while it is 0 is not stored.
- R3: Stores leave on the memory port with mem_we = 1 in the order they were taken, one at a time; an entry stays in the buffer (and stays visible to read lookups) until the edge on which mem_ack is 1 for its transaction.
- R4: Once mem_req is 1, mem_req, mem_we, mem_addr and mem_wdata stay unchanged until the edge on which mem_ack is 1; mem_req is 0 in the cycle after that edge.
- R5: A read that finds no matching entry is issued (mem_req = 1, mem_we = 0, mem_addr = the read address) before any store that has not yet been started; rd_ready stays 0 from its acceptance until its response is presented.
- R6: A read that finds a matching entry gives rsp_valid = 1 with rsp_from_buf = 1 in the cycle after acceptance and causes no memory read.
- R7: When several entries hold the read address, rsp_data is the data of the most recently taken one.
- R8: The data of a memory read appears on rsp_data with rsp_valid = 1 and rsp_from_buf = 0 in the cycle after the edge on which mem_ack is 1, equal to mem_rdata at that edge.
- R9: A write taken on the same edge as a read is not part of that read's lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Processor offers a store |
| wr_addr | input | 32 | Store word address |
| wr_data | input | 32 | Store data |
| wr_ready | output | 1 | Buffer can take a store |
| rd_valid | input | 1 | Read miss request |
| rd_addr | input | 32 | Read miss word address |
| rd_ready | output | 1 | A read can be accepted |
| rsp_valid | output | 1 | Read response present (one cycle) |
| rsp_data | output | 32 | Read response data |
| rsp_from_buf | output | 1 | Response came from a buffered store |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 for store, 0 for read |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory store data |
| mem_ack | input | 1 | Memory completes the transaction on this edge |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
A buffered hit answers in the cycle after the read is accepted, a memory read answers in the cycle after the acknowledging edge, and a new memory request can be seen at the earliest in the cycle after the edge that started it. The bench samples every output on the falling edge, records acceptances at the falling edge before the edge that takes them, and settles each memory completion at the falling edge after its acknowledging edge, which is exactly where both the response and the freed buffer slot are due. The expected read value is the last store to that address taken strictly before the read, and the expected hit flag comes from a mirror queue of stores not yet acknowledged.

// File: rtl/wbuf_pkg.sv
// Shared widths and types of the write buffer.
// Assumes word addressing: one entry holds one full data word.
package wbuf_pkg;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wb_entry_t;

    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_WRITE = 2'd1,
        PORT_READ  = 2'd2
    } port_state_e;
endpackage

// File: rtl/wbuf_store.sv
// Circular entry store of the write buffer.
// Presents the held entries in age order (index 0 = oldest) with a valid
// flag each. Assumes DEPTH is a power of two and that the caller never
// pushes while full nor pops while empty.
module wbuf_store
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  wb_entry_t push_entry,
    input  logic      pop,
    output wb_entry_t ordered [DEPTH],
    output logic      vld [DEPTH],
    output logic      full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    wb_entry_t       slot_q [DEPTH];
    logic [PW-1:0]   head_q;
    logic [CW-1:0]   count_q;
    logic [PW-1:0]   tail;

    assign tail = head_q + PW'(count_q);
    assign full = (count_q == CW'(DEPTH));

    // Write the incoming entry into the free slot after the youngest one.
    always_ff @(posedge clk) begin
        if (push) slot_q[tail] <= push_entry;
    end

    // Advance the oldest-entry pointer and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            count_q <= '0;
        end else begin
            head_q  <= head_q + PW'(pop);
            count_q <= count_q + CW'(push) - CW'(pop);
        end
    end

    // Age-ordered view of the slots.
    for (genvar i = 0; i < DEPTH; i++) begin : g_view
        assign ordered[i] = slot_q[PW'(head_q + PW'(i))];
        assign vld[i]     = (CW'(i) < count_q);
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
    a_r2_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push || pop);
endmodule

// File: rtl/wbuf_match.sv
// Associative lookup of a read address against all held entries.
// Scans oldest to youngest so the youngest matching entry wins.
module wbuf_match
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic [ADDR_W-1:0] look_addr,
    input  wb_entry_t         ordered [DEPTH],
    input  logic              vld [DEPTH],
    output logic              hit,
    output logic [DATA_W-1:0] hit_data
);
    // Priority search: a later (younger) match overrides an earlier one.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && ordered[i].addr == look_addr) begin
                hit      = 1'b1;
                hit_data = ordered[i].data;
            end
        end
    end
endmodule

// File: rtl/wbuf_port_seq.sv
// Sequencer of the single memory port.
// Keeps one transaction outstanding, holds its fields until mem_ack, and
// gives a waiting read miss priority over draining the oldest entry.
// Assumes rd_start is only raised while rd_busy is low.
module wbuf_port_seq
    import wbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic [ADDR_W-1:0] rd_start_addr,
    input  logic              head_valid,
    input  wb_entry_t         head,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    output logic              pop,
    output logic              rd_ack,
    output logic              rd_busy
);
    port_state_e       st_q;
    logic              rd_pend_q;
    logic [ADDR_W-1:0] rd_pend_addr_q;

    assign pop     = (st_q == PORT_WRITE) && mem_ack;
    assign rd_ack  = (st_q == PORT_READ) && mem_ack;
    assign rd_busy = rd_pend_q || (st_q == PORT_READ);

    // Pick the next transaction when idle, park a read that arrives while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= PORT_IDLE;
            mem_req        <= 1'b0;
            mem_we         <= 1'b0;
            mem_addr       <= '0;
            mem_wdata      <= '0;
            rd_pend_q      <= 1'b0;
            rd_pend_addr_q <= '0;
        end else if (st_q == PORT_IDLE) begin
            if (rd_pend_q) begin
                st_q      <= PORT_READ;
                mem_req   <= 1'b1;
                mem_we    <= 1'b0;
                mem_addr  <= rd_pend_addr_q;
                rd_pend_q <= 1'b0;
            end else if (rd_start) begin
                st_q     <= PORT_READ;
                mem_req  <= 1'b1;
                mem_we   <= 1'b0;
                mem_addr <= rd_start_addr;
            end else if (head_valid) begin
                st_q      <= PORT_WRITE;
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= head.addr;
                mem_wdata <= head.data;
            end
        end else begin
            if (rd_start) begin
                rd_pend_q      <= 1'b1;
                rd_pend_addr_q <= rd_start_addr;
            end
            if (mem_ack) begin
                st_q    <= PORT_IDLE;
                mem_req <= 1'b0;
            end
        end
    end

    a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));
    a_r4_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req);
    a_r5_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PORT_IDLE) && rd_pend_q |=> mem_req && !mem_we);
    a_r3_store_is_head: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> head_valid && mem_addr == head.addr && mem_wdata == head.data);
endmodule

// File: rtl/wbuf_bypass_top.sv
// Write buffer with read bypass for a write-through data cache.
// Stores are queued and drained oldest first; a read miss is answered
// from the youngest matching entry or sent to memory ahead of the queue.
// Assumes mem_ack is only raised while mem_req is high.
module wbuf_bypass_top
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_from_buf,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    wb_entry_t         ordered [DEPTH];
    logic              vld [DEPTH];
    logic              full, pop, rd_ack, rd_busy;
    logic              hit;
    logic [DATA_W-1:0] hit_data;
    logic              push, rd_acc, hit_acc, miss_acc;
    wb_entry_t         new_entry;

    assign wr_ready  = !full;
    assign rd_ready  = !rd_busy;
    assign push      = wr_valid && wr_ready;
    assign rd_acc    = rd_valid && rd_ready;
    assign hit_acc   = rd_acc && hit;
    assign miss_acc  = rd_acc && !hit;
    assign new_entry = '{addr: wr_addr, data: wr_data};

    wbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_entry(new_entry),
        .pop(pop), .ordered(ordered), .vld(vld), .full(full)
    );

    wbuf_match #(.DEPTH(DEPTH)) u_match (
        .look_addr(rd_addr), .ordered(ordered), .vld(vld),
        .hit(hit), .hit_data(hit_data)
    );

    wbuf_port_seq u_seq (
        .clk(clk), .rst_n(rst_n), .rd_start(miss_acc), .rd_start_addr(rd_addr),
        .head_valid(vld[0]), .head(ordered[0]),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .pop(pop), .rd_ack(rd_ack), .rd_busy(rd_busy)
    );

    // Register the read response from either the buffer or memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
            rsp_from_buf <= 1'b0;
        end else begin
            rsp_valid    <= hit_acc || rd_ack;
            rsp_from_buf <= hit_acc;
            if (hit_acc)     rsp_data <= hit_data;
            else if (rd_ack) rsp_data <= mem_rdata;
        end
    end

    a_r6_hit_response: assert property (@(posedge clk) disable iff (!rst_n)
        hit_acc |=> rsp_valid && rsp_from_buf);
    a_r8_mem_response: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack |=> rsp_valid && !rsp_from_buf && rsp_data == $past(mem_rdata));
    a_r5_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_acc, rd_ack}));
    a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        miss_acc |=> !rd_ready);
endmodule

// File: tb/sim_wbuf_bypass_top.sv
`timescale 1ns/1ps
module sim_wbuf_bypass_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0, rd_valid = 1'b0, mem_ack = 1'b0;
    logic [31:0] wr_addr = '0, wr_data = '0, rd_addr = '0, mem_rdata = '0;
    logic        wr_ready, rd_ready, rsp_valid, rsp_from_buf, mem_req, mem_we;
    logic [31:0] rsp_data, mem_addr, mem_wdata;

    wbuf_bypass_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_from_buf(rsp_from_buf),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;

    int nvec = 0, nfail = 0, cyc = 0;
    logic        mem_hold = 1'b1, running = 1'b0, prev_req = 1'b0;
    logic [63:0] q[$];
    logic [31:0] memmodel [8];
    logic [31:0] shadow [8];
    logic        t_we;
    logic [31:0] t_addr, t_data;
    int          lat = 0;
    logic        hit_pend = 1'b0, miss_wait = 1'b0, miss_out = 1'b0;
    logic [31:0] hit_exp, miss_exp, miss_addr;

    function automatic logic [31:0] init_val(int k);
        return 32'hA5A5_0000 + 32'(k * 17);
    endfunction
    function automatic int idx(logic [31:0] a);
        return int'(a[4:2]);
    endfunction
    function automatic logic [31:0] adr(int k);
        return 32'h100 + 32'(k * 4);
    endfunction
    function automatic logic q_has(logic [31:0] a);
        foreach (q[i]) if (q[i][63:32] == a) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    // Memory responder, reference model and per-cycle checks.
    always @(negedge clk) begin
        logic due, due_buf, ok;
        logic [31:0] due_data;
        cyc++;
        if (cyc > 150000) begin
            nvec++; nfail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
        if (running) begin
            due = hit_pend; due_buf = 1'b1; due_data = hit_exp; hit_pend = 1'b0;
            if (mem_ack) begin
                mem_ack = 1'b0;
                if (t_we) begin
                    ok = (q.size() > 0) && (q[0] == {t_addr, t_data});
                    chk(ok, "R3 drain order", t_addr, (q.size() > 0) ? q[0][63:32] : 32'hx);
                    if (q.size() > 0) void'(q.pop_front());
                    memmodel[idx(t_addr)] = t_data;
                end else begin
                    chk(miss_out && t_addr == miss_addr, "R5 read address", t_addr, miss_addr);
                    due = 1'b1; due_buf = 1'b0; due_data = miss_exp; miss_out = 1'b0;
                end
            end
            if (due) begin
                chk(rsp_valid, "R6/R8 response due", 32'(rsp_valid), 1);
                chk(rsp_from_buf == due_buf, due_buf ? "R6 from buffer" : "R8 from memory",
                    32'(rsp_from_buf), 32'(due_buf));
                chk(rsp_data == due_data, due_buf ? "R7 hit data" : "R8 memory data", rsp_data, due_data);
            end else if (rsp_valid) chk(1'b0, "R6/R8 spurious response", 1, 0);
            chk(wr_ready == (q.size() < 4), "R2 wr_ready vs occupancy", 32'(wr_ready), 32'(q.size() < 4));
            chk(rd_ready == !miss_out, "R5 rd_ready while miss open", 32'(rd_ready), 32'(!miss_out));
            if (mem_req && !prev_req) begin
                if (miss_wait) begin
                    chk(!mem_we, "R5 read before further drain", 32'(mem_we), 0);
                    if (!mem_we) miss_wait = 1'b0;
                end else chk(mem_we, "R6 no memory read without miss", 32'(mem_we), 1);
            end
            prev_req = mem_req;
            if (rd_valid && rd_ready) begin
                if (q_has(rd_addr)) begin
                    hit_pend = 1'b1; hit_exp = shadow[idx(rd_addr)];
                end else begin
                    miss_wait = 1'b1; miss_out = 1'b1; miss_addr = rd_addr;
                    miss_exp = shadow[idx(rd_addr)];
                end
            end
            if (wr_valid && wr_ready) begin
                q.push_back({wr_addr, wr_data});
                shadow[idx(wr_addr)] = wr_data;
            end
            if (mem_req && !mem_ack && !mem_hold) begin
                if (lat == 0) begin
                    mem_ack = 1'b1; t_we = mem_we; t_addr = mem_addr; t_data = mem_wdata;
                    mem_rdata = mem_we ? 32'h0 : memmodel[idx(mem_addr)];
                    lat = $urandom_range(0, 3);
                end else lat--;
            end
        end
    end

    task automatic do_write(input logic [31:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic do_read(input logic [31:0] a);
        @(posedge clk); #1;
        rd_valid = 1'b1; rd_addr = a;
        @(negedge clk);
        while (!rd_ready) @(negedge clk);
        @(posedge clk); #1;
        rd_valid = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 8; k++) begin
            memmodel[k] = init_val(k);
            shadow[k]   = init_val(k);
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(wr_ready, "R1 wr_ready", 32'(wr_ready), 1);
        chk(rd_ready, "R1 rd_ready", 32'(rd_ready), 1);
        chk(!mem_req, "R1 mem_req", 32'(mem_req), 0);
        chk(!rsp_valid, "R1 rsp_valid", 32'(rsp_valid), 0);
        running = 1'b1;

        // R2/R7: fill with memory stalled, two stores to the same address
        mem_hold = 1'b1;
        do_write(adr(0), 32'h1111_0001);
        do_write(adr(1), 32'h2222_0002);
        do_write(adr(0), 32'h3333_0003);
        do_write(adr(2), 32'h4444_0004);
        @(negedge clk);
        chk(!wr_ready, "R2 full drops wr_ready", 32'(wr_ready), 0);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = adr(3); wr_data = 32'hDEAD_0005;
        wait_cycles(3);
        wr_valid = 1'b0;
        do_read(adr(0));         // R7: youngest of two matches -> 3333_0003
        do_read(adr(3));         // R2: rejected store absent -> miss, R5 parks it
        wait_cycles(3);
        mem_hold = 1'b0;         // store in flight completes, then R5 read goes first
        wait_cycles(40);
        do_read(adr(0));         // R8: now from memory
        wait_cycles(10);
        // R9: store and read to the same idle address on the same edge
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = adr(5); wr_data = 32'h7777_0009;
        rd_valid = 1'b1; rd_addr = adr(5);
        @(posedge clk); #1;
        wr_valid = 1'b0; rd_valid = 1'b0;
        wait_cycles(20);
        do_read(adr(5));         // R6: now a buffer hit or memory value of the store
        wait_cycles(20);

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            @(posedge clk); #1;
            wr_valid = ($urandom_range(0, 99) < 45);
            wr_addr  = adr($urandom_range(0, 7));
            wr_data  = $urandom;
            rd_valid = ($urandom_range(0, 99) < 25);
            rd_addr  = adr($urandom_range(0, 7));
            mem_hold = ($urandom_range(0, 99) < 10);
        end
        @(posedge clk); #1;
        wr_valid = 1'b0; rd_valid = 1'b0; mem_hold = 1'b0;
        wait_cycles(60);
        chk(q.size() == 0, "R3 buffer drained", 32'(q.size()), 0);
        finish_run();
    end
endmodule